// File: doc/BRIEF.md
# Dual-Port Resource Register Decoder with Mailboxes

This block sits between two independent bus ports and a pair of FIFOs. Each port has an enable and a read/write control. On every enabled clock edge the block decodes the port's resource select and then takes one of three actions: it fires a registered FIFO strobe, it reads or writes a mailbox, or, on port A only, it reaches the flag-offset and control registers. The FIFO storage is outside the block. The block drives only the strobes and the four almost-empty and almost-full offset values that the FIFO flag logic uses.

There are two mailboxes, one for each direction. The A-to-B mailbox is written by port A and read by port B. The B-to-A mailbox is written by port B and read by port A. Writing a mailbox raises its full flag. Reading it from the opposite port lowers the flag. Read data and strobes are registered, so they appear one clock after the access that produced them.

Top module: `port_resource_decoder`

## Requirements
- R1: Synchronous reset has these effects. Every offset register becomes 8. Both mailbox full flags and both mailbox data words become 0. The control register becomes 0. Both read-data outputs become 0. All four FIFO strobes become 0.
- R2: Port A code 3'b111 is FIFO access. An enabled write pulses `a_fifo_wr` and an enabled read pulses `a_fifo_rd`, in both cases for one cycle on the clock after the access. `a_rdata` keeps its value.
- R3: Port B select 1 is FIFO access. An enabled write pulses `b_fifo_wr` and an enabled read pulses `b_fifo_rd`, one cycle after the access. `b_rdata` keeps its value.
- R4: Port A codes 3'b000, 3'b001, 3'b010 and 3'b011 address the AF2, AE2, AF1 and AE1 offset registers. A write stores `a_wdata[8:0]`. A read returns the zero-extended offset on `a_rdata` one cycle later.
- R5: Port A code 3'b101 addresses all four offsets as one word, with AF2 in bits 35:27, AE2 in 26:18, AF1 in 17:9 and AE1 in 8:0. A write loads all four offsets. A read returns them packed in the same layout.
- R6: Port A code 3'b100 addresses the control register. A write loads `ctrl_q` from `a_wdata`. A read returns zero on `a_rdata` and leaves every register unchanged.
- R7: A port A write with code 3'b110 stores the word in the A-to-B mailbox and sets `mbx_ab_full`. A port B read with select 0 returns that word on `b_rdata` and clears `mbx_ab_full`.
- R8: A port B write with select 0 stores the word in the B-to-A mailbox and sets `mbx_ba_full`. A port A read with code 3'b110 returns that word on `a_rdata` and clears `mbx_ba_full`.
- R9: Sometimes a mailbox is written and read in the same cycle. The full flag then stays set, the reader gets the previously stored word, and the new word is kept.
- R10: While a port's enable is low, its select, control and data are ignored. No strobe fires, no register changes, and its read data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port A access enable |
| a_rw | input | 1 | Port A direction, 1 = read, 0 = write |
| a_sel | input | 3 | Port A resource select |
| a_wdata | input | 36 | Port A write data |
| a_rdata | output | 36 | Port A registered read data |
| a_fifo_wr | output | 1 | Port A FIFO write strobe |
| a_fifo_rd | output | 1 | Port A FIFO read strobe |
| b_en | input | 1 | Port B access enable |
| b_rw | input | 1 | Port B direction, 1 = read, 0 = write |
| b_sel | input | 1 | Port B resource select |
| b_wdata | input | 36 | Port B write data |
| b_rdata | output | 36 | Port B registered read data |
| b_fifo_wr | output | 1 | Port B FIFO write strobe |
| b_fifo_rd | output | 1 | Port B FIFO read strobe |
| ctrl_q | output | 36 | Control register contents |
| af2_ofs | output | 9 | Almost-full offset, FIFO 2 |
| ae2_ofs | output | 9 | Almost-empty offset, FIFO 2 |
| af1_ofs | output | 9 | Almost-full offset, FIFO 1 |
| ae1_ofs | output | 9 | Almost-empty offset, FIFO 1 |
| mbx_ab_full | output | 1 | A-to-B mailbox holds unread data |
| mbx_ba_full | output | 1 | B-to-A mailbox holds unread data |

## Verification
The hardest case to reach is a mailbox collision. This is the cycle in which one port writes a mailbox while the other port reads the same mailbox. Both ports have to land on the right select codes with opposite directions on the same edge. The flag must then stay set and the reader must see the old word. A directed step drives exactly that pair of accesses on both mailboxes after each has been preloaded with a known word. A long random phase follows, with both ports biased toward the mailbox codes, so collisions also occur next to clears and offset writes. The reference model is compared on every clock, so a wrong flag or stale data is caught in the cycle it appears.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
  localparam int NOFS = 4;

  localparam logic [2:0] SEL_A_FIFO = 3'b111;
  localparam logic [2:0] SEL_A_MBX  = 3'b110;
  localparam logic [2:0] SEL_A_ALL  = 3'b101;
  localparam logic [2:0] SEL_A_CTRL = 3'b100;

  localparam logic SEL_B_FIFO = 1'b1;
  localparam logic SEL_B_MBX  = 1'b0;

  typedef struct packed {
    logic            fifo_wr;
    logic            fifo_rd;
    logic            mbx_wr;
    logic            mbx_rd;
    logic            all_wr;
    logic            ctrl_wr;
    logic            reg_rd;
    logic [NOFS-1:0] ofs_wr;
  } a_dec_t;
endpackage

// File: rtl/rrd_a_decode.sv
module rrd_a_decode
  import rrd_pkg::*;
(
  input  logic       en,
  input  logic       rw,
  input  logic [2:0] sel,
  output a_dec_t     dec
);
  logic wr_cyc;
  logic rd_cyc;

  assign wr_cyc = en && !rw;
  assign rd_cyc = en && rw;

  always_comb begin
    dec.fifo_wr = wr_cyc && (sel == SEL_A_FIFO);
    dec.fifo_rd = rd_cyc && (sel == SEL_A_FIFO);
    dec.mbx_wr  = wr_cyc && (sel == SEL_A_MBX);
    dec.mbx_rd  = rd_cyc && (sel == SEL_A_MBX);
    dec.all_wr  = wr_cyc && (sel == SEL_A_ALL);
    dec.ctrl_wr = wr_cyc && (sel == SEL_A_CTRL);
    dec.reg_rd  = rd_cyc && (sel != SEL_A_FIFO);
  end

  for (genvar i = 0; i < NOFS; i++) begin : g_ofs_dec
    assign dec.ofs_wr[i] = wr_cyc && !sel[2] && (sel[1:0] == i[1:0]);
  end
endmodule

// File: rtl/rrd_offsets.sv
module rrd_offsets
  import rrd_pkg::*;
#(
  parameter int DW      = 36,
  parameter int OW      = 9,
  parameter int OFS_RST = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NOFS-1:0]           wr_one,
  input  logic                      wr_all,
  input  logic [DW-1:0]             wdata,
  output logic [NOFS-1:0][OW-1:0]   ofs_q,
  output logic [DW-1:0]             packed_q
);
  localparam int USED = NOFS * OW;

  for (genvar i = 0; i < NOFS; i++) begin : g_ofs
    always_ff @(posedge clk) begin
      if (rst)            ofs_q[i] <= OW'(OFS_RST);
      else if (wr_one[i]) ofs_q[i] <= wdata[OW-1:0];
      else if (wr_all)    ofs_q[i] <= wdata[DW-1-i*OW -: OW];
    end

    assign packed_q[DW-1-i*OW -: OW] = ofs_q[i];

    assert_ofs_write_R4: assert property (@(posedge clk) disable iff (rst)
      wr_one[i] |=> ofs_q[i] == $past(wdata[OW-1:0]));

    assert_ofs_all_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_all && !wr_one[i]) |=> ofs_q[i] == $past(wdata[DW-1-i*OW -: OW]));

    assert_ofs_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (!wr_one[i] && !wr_all) |=> $stable(ofs_q[i]));
  end

  if (DW > USED) begin : g_pad
    assign packed_q[DW-USED-1:0] = '0;
  end
endmodule

// File: rtl/rrd_mailbox.sv
module rrd_mailbox #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data_q,
  output logic          full_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr) data_q <= wdata;
      if (wr)      full_q <= 1'b1;
      else if (rd) full_q <= 1'b0;
    end
  end

  assert_mbx_set_R7: assert property (@(posedge clk) disable iff (rst)
    wr |=> full_q && data_q == $past(wdata));

  assert_mbx_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr) |=> !full_q);

  assert_mbx_collide_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && wr) |=> full_q);

  assert_mbx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!rd && !wr) |=> $stable(full_q) && $stable(data_q));
endmodule

// File: rtl/port_resource_decoder.sv
module port_resource_decoder
  import rrd_pkg::*;
#(
  parameter int DW      = 36,
  parameter int OW      = 9,
  parameter int OFS_RST = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic          a_rw,
  input  logic [2:0]    a_sel,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_fifo_wr,
  output logic          a_fifo_rd,
  input  logic          b_en,
  input  logic          b_rw,
  input  logic          b_sel,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_fifo_wr,
  output logic          b_fifo_rd,
  output logic [DW-1:0] ctrl_q,
  output logic [OW-1:0] af2_ofs,
  output logic [OW-1:0] ae2_ofs,
  output logic [OW-1:0] af1_ofs,
  output logic [OW-1:0] ae1_ofs,
  output logic          mbx_ab_full,
  output logic          mbx_ba_full
);
  localparam int PAD = DW - OW;

  a_dec_t                  a_dec;
  logic                    b_fifo_wr_d, b_fifo_rd_d, b_mbx_wr, b_mbx_rd;
  logic [NOFS-1:0][OW-1:0] ofs_q;
  logic [DW-1:0]           ofs_packed;
  logic [DW-1:0]           ab_data, ba_data;

  rrd_a_decode u_a_dec (
    .en  (a_en),
    .rw  (a_rw),
    .sel (a_sel),
    .dec (a_dec)
  );

  assign b_fifo_wr_d = b_en && !b_rw && (b_sel == SEL_B_FIFO);
  assign b_fifo_rd_d = b_en &&  b_rw && (b_sel == SEL_B_FIFO);
  assign b_mbx_wr    = b_en && !b_rw && (b_sel == SEL_B_MBX);
  assign b_mbx_rd    = b_en &&  b_rw && (b_sel == SEL_B_MBX);

  rrd_offsets #(.DW(DW), .OW(OW), .OFS_RST(OFS_RST)) u_ofs (
    .clk      (clk),
    .rst      (rst),
    .wr_one   (a_dec.ofs_wr),
    .wr_all   (a_dec.all_wr),
    .wdata    (a_wdata),
    .ofs_q    (ofs_q),
    .packed_q (ofs_packed)
  );

  rrd_mailbox #(.DW(DW)) u_mbx_ab (
    .clk    (clk),
    .rst    (rst),
    .wr     (a_dec.mbx_wr),
    .rd     (b_mbx_rd),
    .wdata  (a_wdata),
    .data_q (ab_data),
    .full_q (mbx_ab_full)
  );

  rrd_mailbox #(.DW(DW)) u_mbx_ba (
    .clk    (clk),
    .rst    (rst),
    .wr     (b_mbx_wr),
    .rd     (a_dec.mbx_rd),
    .wdata  (b_wdata),
    .data_q (ba_data),
    .full_q (mbx_ba_full)
  );

  assign af2_ofs = ofs_q[0];
  assign ae2_ofs = ofs_q[1];
  assign af1_ofs = ofs_q[2];
  assign ae1_ofs = ofs_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (a_dec.ctrl_wr) begin
      ctrl_q <= a_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
    end else if (a_dec.reg_rd) begin
      case (a_sel)
        SEL_A_MBX:  a_rdata <= ba_data;
        SEL_A_ALL:  a_rdata <= ofs_packed;
        SEL_A_CTRL: a_rdata <= '0;
        default:    a_rdata <= {{PAD{1'b0}}, ofs_q[a_sel[1:0]]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_rdata <= '0;
    end else if (b_mbx_rd) begin
      b_rdata <= ab_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_fifo_wr <= 1'b0;
      a_fifo_rd <= 1'b0;
      b_fifo_wr <= 1'b0;
      b_fifo_rd <= 1'b0;
    end else begin
      a_fifo_wr <= a_dec.fifo_wr;
      a_fifo_rd <= a_dec.fifo_rd;
      b_fifo_wr <= b_fifo_wr_d;
      b_fifo_rd <= b_fifo_rd_d;
    end
  end

  assert_a_fifo_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (a_en && a_sel == SEL_A_FIFO) |=> (a_fifo_wr != a_fifo_rd) && $stable(a_rdata));

  assert_b_fifo_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (b_en && b_sel == SEL_B_FIFO) |=> (b_fifo_wr != b_fifo_rd) && $stable(b_rdata));

  assert_ctrl_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (a_en && a_rw && a_sel == SEL_A_CTRL) |=> a_rdata == '0 && $stable(ctrl_q));

  assert_idle_a_R10: assert property (@(posedge clk) disable iff (rst)
    !a_en |=> !a_fifo_wr && !a_fifo_rd && $stable(a_rdata) && $stable(ctrl_q));

  assert_idle_b_R10: assert property (@(posedge clk) disable iff (rst)
    !b_en |=> !b_fifo_wr && !b_fifo_rd && $stable(b_rdata));

  assert_reset_flags_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !mbx_ab_full && !mbx_ba_full && ctrl_q == '0);
endmodule

// File: tb/port_resource_decoder_tb.sv
`timescale 1ns/1ps
module port_resource_decoder_tb;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst;
  logic a_en, a_rw, b_en, b_rw, b_sel;
  logic [2:0] a_sel;
  logic [DW-1:0] a_wdata, b_wdata;
  logic [DW-1:0] a_rdata, b_rdata, ctrl_q;
  logic a_fifo_wr, a_fifo_rd, b_fifo_wr, b_fifo_rd;
  logic [8:0] af2_ofs, ae2_ofs, af1_ofs, ae1_ofs;
  logic mbx_ab_full, mbx_ba_full;

  always #4 clk = ~clk;

  port_resource_decoder u_dut (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_rw(a_rw), .a_sel(a_sel), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_fifo_wr(a_fifo_wr), .a_fifo_rd(a_fifo_rd),
    .b_en(b_en), .b_rw(b_rw), .b_sel(b_sel), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .b_fifo_wr(b_fifo_wr), .b_fifo_rd(b_fifo_rd),
    .ctrl_q(ctrl_q), .af2_ofs(af2_ofs), .ae2_ofs(ae2_ofs), .af1_ofs(af1_ofs),
    .ae1_ofs(ae1_ofs), .mbx_ab_full(mbx_ab_full), .mbx_ba_full(mbx_ba_full)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // reference model state; index 0..3 = AF2, AE2, AF1, AE1
  logic [DW-1:0] m_ard, m_brd, m_ab, m_ba, m_ctrl;
  logic [8:0]    m_ofs [4];
  bit m_abf, m_baf, m_afw, m_afr, m_bfw, m_bfr;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] m_pack();
    return {m_ofs[0], m_ofs[1], m_ofs[2], m_ofs[3]};
  endfunction

  task automatic model_step();
    logic [DW-1:0] old_ab, old_ba, pk;
    bit aw_mbx, ar_mbx, bw_mbx, br_mbx;
    old_ab = m_ab; old_ba = m_ba; pk = m_pack();
    m_afw = 0; m_afr = 0; m_bfw = 0; m_bfr = 0;
    if (rst) begin
      m_ard = '0; m_brd = '0; m_ab = '0; m_ba = '0; m_ctrl = '0;
      m_abf = 0; m_baf = 0;
      for (int i = 0; i < 4; i++) m_ofs[i] = 9'd8;
      return;
    end
    aw_mbx = a_en && !a_rw && a_sel == 3'd6;
    ar_mbx = a_en &&  a_rw && a_sel == 3'd6;
    bw_mbx = b_en && !b_rw && b_sel == 1'b0;
    br_mbx = b_en &&  b_rw && b_sel == 1'b0;
    if (a_en) begin
      if (a_rw) begin
        case (a_sel)
          3'd7: m_afr = 1;
          3'd6: m_ard = old_ba;
          3'd5: m_ard = pk;
          3'd4: m_ard = '0;
          default: m_ard = DW'(m_ofs[a_sel[1:0]]);
        endcase
      end else begin
        case (a_sel)
          3'd7: m_afw = 1;
          3'd6: m_ab = a_wdata;
          3'd5: for (int i = 0; i < 4; i++) m_ofs[i] = a_wdata[35-9*i -: 9];
          3'd4: m_ctrl = a_wdata;
          default: m_ofs[a_sel[1:0]] = a_wdata[8:0];
        endcase
      end
    end
    if (b_en) begin
      if (b_sel) begin
        if (b_rw) m_bfr = 1; else m_bfw = 1;
      end else begin
        if (b_rw) m_brd = old_ab; else m_ba = b_wdata;
      end
    end
    if (aw_mbx) m_abf = 1; else if (br_mbx) m_abf = 0;
    if (bw_mbx) m_baf = 1; else if (ar_mbx) m_baf = 0;
  endtask

  task automatic compare();
    chk("a_rdata", 64'(a_rdata), 64'(m_ard));
    chk("b_rdata", 64'(b_rdata), 64'(m_brd));
    chk("strobes", 64'({a_fifo_wr, a_fifo_rd, b_fifo_wr, b_fifo_rd}),
        64'({m_afw, m_afr, m_bfw, m_bfr}));
    chk("ctrl_q", 64'(ctrl_q), 64'(m_ctrl));
    chk("offsets", 64'({af2_ofs, ae2_ofs, af1_ofs, ae1_ofs}),
        64'({m_ofs[0], m_ofs[1], m_ofs[2], m_ofs[3]}));
    chk("mbx_flags", 64'({mbx_ab_full, mbx_ba_full}), 64'({m_abf, m_baf}));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    a_en = 0; b_en = 0; a_rw = 0; b_rw = 0; a_sel = 3'd7; b_sel = 1'b1;
    a_wdata = '0; b_wdata = '0;
  endtask

  task automatic acc_a(bit rw, logic [2:0] sel, logic [DW-1:0] d);
    idle(); a_en = 1; a_rw = rw; a_sel = sel; a_wdata = d; cyc();
  endtask

  task automatic acc_b(bit rw, bit sel, logic [DW-1:0] d);
    idle(); b_en = 1; b_rw = rw; b_sel = sel; b_wdata = d; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(); rst = 1;
    cur_req = "R1";
    @(negedge clk);
    repeat (3) cyc();
    rst = 0;
    cyc();

    cur_req = "R2";
    acc_a(0, 3'd7, 36'h123456789); acc_a(1, 3'd7, '0); idle(); cyc();

    cur_req = "R3";
    acc_b(0, 1'b1, 36'hABCDE0123); acc_b(1, 1'b1, '0); idle(); cyc();

    cur_req = "R4";
    for (int s = 0; s < 4; s++) acc_a(0, 3'(s), 36'hFFFFFFE00 | 36'(9'h11 * (s + 1)));
    for (int s = 0; s < 4; s++) acc_a(1, 3'(s), '0);

    cur_req = "R5";
    acc_a(0, 3'd5, {9'h1A5, 9'h05A, 9'h1FF, 9'h001});
    acc_a(1, 3'd5, '0);
    acc_a(1, 3'd0, '0); acc_a(1, 3'd3, '0);
    acc_a(0, 3'd2, 36'h0000000C3); acc_a(1, 3'd5, '0);

    cur_req = "R6";
    acc_a(0, 3'd4, 36'h9F00FF00F);
    acc_a(1, 3'd4, '0); idle(); cyc();

    cur_req = "R7";
    acc_a(0, 3'd6, 36'h5A5A5A5A5); idle(); cyc();
    acc_b(1, 1'b0, '0); idle(); cyc();

    cur_req = "R8";
    acc_b(0, 1'b0, 36'h0C0FFEE11); idle(); cyc();
    acc_a(1, 3'd6, '0); idle(); cyc();

    cur_req = "R9";
    acc_a(0, 3'd6, 36'h111111111);
    idle(); a_en = 1; a_rw = 0; a_sel = 3'd6; a_wdata = 36'h222222222;
    b_en = 1; b_rw = 1; b_sel = 1'b0; cyc();
    acc_b(1, 1'b0, '0);
    acc_b(0, 1'b0, 36'h333333333);
    idle(); b_en = 1; b_rw = 0; b_sel = 1'b0; b_wdata = 36'h444444444;
    a_en = 1; a_rw = 1; a_sel = 3'd6; cyc();
    acc_a(1, 3'd6, '0);

    cur_req = "R10";
    for (int s = 0; s < 8; s++) begin
      idle(); a_rw = s[0]; a_sel = 3'(s); a_wdata = 36'hFFFFFFFFF;
      b_rw = s[1]; b_sel = s[2]; b_wdata = 36'hEEEEEEEEE; cyc();
    end

    cur_req = "RND";
    for (int n = 0; n < 3000; n++) begin
      a_en = ($urandom_range(0, 3) != 0);
      a_rw = $urandom_range(0, 1);
      a_sel = ($urandom_range(0, 1) != 0) ? 3'd6 : 3'($urandom_range(0, 7));
      a_wdata = {4'($urandom), 32'($urandom)};
      b_en = ($urandom_range(0, 3) != 0);
      b_rw = $urandom_range(0, 1);
      b_sel = ($urandom_range(0, 2) == 0);
      b_wdata = {4'($urandom), 32'($urandom)};
      rst = (n == 1500);
      cyc();
    end
    rst = 0; idle(); cyc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule